// File: doc/BRIEF.md
# Stackable Transparent-Latch Register File

The block stores words in banks of four, each word held in a level-sensitive latch rather than a flip-flop. A write port and a read port work side by side, each with its own address and its own active-low enable. While the write enable is low, the addressed word is open and follows the write data. When the enable returns high, the word keeps the last value it saw. The read port always selects the word named by the read address. The read enable only decides whether that word is driven onto the output or whether the output floats.

Several banks can share one output bus. Set the bank count as a parameter. The upper address bits then pick the bank on both ports, and the read side decodes them into enables of which at most one is active. With no enable active the output is high-impedance, so other drivers or a pull network can own the bus. There is no clock. The only sequential control is the latch enable and the asynchronous active-low reset, which clears every word.

Top module: `rf_stack`

## Requirements
- R1: While rst_ni is low, every word is cleared to 0. After release, reading any address returns 0 until that word is written.
- R2: A low pulse on we_ni loads wr_data_i into the word at wr_addr_i. The word keeps that value after we_ni returns high. Reads of it then return the value unchanged.
- R3: While we_ni stays low, the addressed word follows every change of wr_data_i. It keeps the value present when we_ni rises.
- R4: While we_ni is high, changes on wr_data_i and wr_addr_i leave every word unchanged.
- R5: With re_ni low, rd_data_o shows the word at rd_addr_i, not inverted. In each bank, address bits [1:0] form the word index with bit 1 as the most significant bit, so 00 selects word 0 and 11 selects word 3.
- R6: With re_ni high, no bank drives rd_data_o and all of its bits are high-impedance.
- R7: A read of one word while a different word is being written returns the stored value of the read word, unaffected by the write.
- R8: With we_ni and re_ni both low and rd_addr_i equal to wr_addr_i, rd_data_o follows wr_data_i combinationally.
- R9: Address bits above bit 1 select the bank, so global word n is bank n/4, word n%4. A write to one bank leaves the other banks unchanged, and at most one bank drives the output at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low clear of all words |
| we_ni | input | 1 | Active-low write enable; the addressed word is transparent while low |
| wr_addr_i | input | ADDR_W | Write address: bank in the upper bits, word in bits [1:0] |
| wr_data_i | input | WORD_W | Write data |
| re_ni | input | 1 | Active-low read enable; high sets the output to high-impedance |
| rd_addr_i | input | ADDR_W | Read address: bank in the upper bits, word in bits [1:0] |
| rd_data_o | output | WORD_W | Read data, high-impedance when no bank is enabled |

## Verification
The bench writes a distinct arithmetic pattern, (3n+1) mod 16, into every word of two banks. It then reads each word back. A wrong word index, a bank decode error, or a bit inversion each show up as a mismatch on a known value. A sweep of all sixteen data values through one word exposes any stuck or swapped data bit.

Three further sequences cover the open-latch behaviour:
- Toggling data and address with the write enable high shows whether the latches really close.
- Changing data while the enable stays low, with the read address on the same word, separates write-through and final capture from a plain edge capture.
- Reads of other words during an open write show whether the write leaks into them.

Reads with the read enable high, against a pulled-up bus and stored values that are never all ones, distinguish a floating output from a driven one.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned WORDS_PER_BANK = 4;
  localparam int unsigned WIDX_W         = 2;

  function automatic int unsigned bank_bits(input int unsigned n_banks);
    return (n_banks > 1) ? $clog2(n_banks) : 0;
  endfunction
endpackage

// File: rtl/rf_word_latch.sv
module rf_word_latch #(
  parameter int unsigned WORD_W = 4
) (
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o
);
  always_latch begin
    if (!rst_ni)     q_o = '0;
    else if (load_i) q_o = d_i;
  end

  // R1
  always @(posedge rst_ni) begin
    rst_clear_chk: assert (q_o == '0);
  end

  // R2
  always @(negedge load_i) begin
    if (rst_ni) begin
      wr_capture_chk: assert (q_o == d_i);
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned WORD_W = 4
) (
  input  logic                      rst_ni,
  input  logic                      we_ni,
  input  logic [rf_pkg::WIDX_W-1:0] wr_idx_i,
  input  logic [WORD_W-1:0]         wr_data_i,
  input  logic                      rd_en_i,
  input  logic [rf_pkg::WIDX_W-1:0] rd_idx_i,
  output logic [WORD_W-1:0]         rd_word_o,
  output logic                      drive_o
);
  import rf_pkg::*;

  logic [WORDS_PER_BANK-1:0] load;
  logic [WORD_W-1:0]         words [WORDS_PER_BANK];

  for (genvar w = 0; w < WORDS_PER_BANK; w++) begin : g_word
    assign load[w] = !we_ni && (wr_idx_i == WIDX_W'(w));
    rf_word_latch #(.WORD_W(WORD_W)) u_word (
      .rst_ni (rst_ni),
      .load_i (load[w]),
      .d_i    (wr_data_i),
      .q_o    (words[w])
    );
  end

  // read select ignores both enables; rd_en_i only gates the driver
  assign rd_word_o = words[rd_idx_i];
  assign drive_o   = rd_en_i;

  // R4
  always_comb begin
    if (rst_ni && we_ni) begin
      closed_no_load_chk: assert (load == '0);
    end
  end
endmodule

// File: rtl/rf_stack.sv
module rf_stack #(
  parameter int unsigned WORD_W    = 4,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned ADDR_W   = rf_pkg::WIDX_W + rf_pkg::bank_bits(NUM_BANKS)
) (
  input  logic              rst_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              re_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  import rf_pkg::*;

  logic [ADDR_W-1:0]    wr_bank, rd_bank;
  logic [NUM_BANKS-1:0] bank_drv;
  logic [WORD_W-1:0]    bank_word [NUM_BANKS];
  logic [WORD_W-1:0]    bus_val;

  assign wr_bank = wr_addr_i >> WIDX_W;
  assign rd_bank = rd_addr_i >> WIDX_W;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we_n, bank_re;
    assign bank_we_n = we_ni || (wr_bank != ADDR_W'(b));
    assign bank_re   = !re_ni && (rd_bank == ADDR_W'(b));
    rf_bank #(.WORD_W(WORD_W)) u_bank (
      .rst_ni    (rst_ni),
      .we_ni     (bank_we_n),
      .wr_idx_i  (wr_addr_i[WIDX_W-1:0]),
      .wr_data_i (wr_data_i),
      .rd_en_i   (bank_re),
      .rd_idx_i  (rd_addr_i[WIDX_W-1:0]),
      .rd_word_o (bank_word[b]),
      .drive_o   (bank_drv[b])
    );
  end

  // wired bus: at most one driver is active
  always_comb begin
    bus_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_drv[b]) bus_val = bus_val | bank_word[b];
    end
  end

  assign rd_data_o = (|bank_drv) ? bus_val : 'z;

  // R9
  always_comb begin
    if (rst_ni) begin
      bus_onehot_chk: assert ($onehot0(bank_drv));
    end
  end

  // R6
  always_comb begin
    if (rst_ni && re_ni) begin
      idle_no_drive_chk: assert (bank_drv == '0);
    end
  end
endmodule

// File: tb/rf_stack_tb.sv
module rf_stack_tb;
  localparam int unsigned W  = 4;
  localparam int unsigned NB = 2;
  localparam int unsigned AW = 2 + $clog2(NB);
  localparam int unsigned NW = 4 * NB;

  logic          clk = 1'b0;
  logic          rst_ni, we_ni, re_ni;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [W-1:0]  wr_data;
  tri1  [W-1:0]  rd_bus;

  logic [W-1:0]  ref_mem [NW];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rf_stack #(.WORD_W(W), .NUM_BANKS(NB)) u_dut (
    .rst_ni    (rst_ni),
    .we_ni     (we_ni),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .re_ni     (re_ni),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_bus)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int n);
    return W'((3 * n + 1) % 16);
  endfunction

  task automatic write_word(input int a, input logic [W-1:0] d);
    @(negedge clk); wr_addr = AW'(a); wr_data = d;
    @(negedge clk); we_ni = 1'b0;
    @(negedge clk); we_ni = 1'b1;
    ref_mem[a] = d;
  endtask

  task automatic read_word(input int a, input string req);
    @(negedge clk); re_ni = 1'b0; rd_addr = AW'(a);
    @(posedge clk); #1;
    check(req, rd_bus, ref_mem[a]);
  endtask

  initial begin
    rst_ni = 1'b0; we_ni = 1'b1; re_ni = 1'b1;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: cleared after reset
    for (int i = 0; i < NW; i++) read_word(i, "R1");

    // R2 R5 R9: distinct pattern into every word of both banks
    for (int i = 0; i < NW; i++) write_word(i, pat(i));
    for (int i = 0; i < NW; i++) read_word(i, "R5_R9");

    // R2: all 16 values through word 3, neighbours untouched
    for (int v = 0; v < 16; v++) begin
      write_word(3, W'(v));
      read_word(3, "R2");
      read_word(7, "R9");
    end
    write_word(3, pat(3));

    // R4: data/address wiggle with write enable high
    @(negedge clk); re_ni = 1'b1;
    for (int i = 0; i < NW; i++) begin
      @(negedge clk); wr_addr = AW'(i); wr_data = ~pat(i);
    end
    for (int i = 0; i < NW; i++) read_word(i, "R4");

    // R3 R8: open latch, data changes, read-through on the same word
    @(negedge clk); wr_addr = AW'(2); wr_data = 4'h9; re_ni = 1'b0; rd_addr = AW'(2);
    @(negedge clk); we_ni = 1'b0;
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); wr_data = W'(v * 5 + 2);
      #1 check("R8", rd_bus, W'(v * 5 + 2));
    end
    @(negedge clk); wr_data = 4'hc;
    @(negedge clk); we_ni = 1'b1; ref_mem[2] = 4'hc;
    @(negedge clk); wr_data = 4'h0;
    read_word(2, "R3");

    // R7: read others while word 5 is open
    @(negedge clk); wr_addr = AW'(5); wr_data = 4'h2;
    @(negedge clk); we_ni = 1'b0;
    for (int i = 0; i < NW; i++) begin
      if (i != 5) read_word(i, "R7");
    end
    @(negedge clk); wr_data = 4'h8;
    @(negedge clk); we_ni = 1'b1; ref_mem[5] = 4'h8;
    read_word(5, "R7");
    read_word(1, "R7");

    // R6: read enable high floats the pulled-up bus
    for (int i = 0; i < NW; i++) begin
      @(negedge clk); re_ni = 1'b1; rd_addr = AW'(i);
      @(posedge clk); #1;
      check("R6", rd_bus, 4'hf);
    end

    // R1: reset again clears everything
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    for (int i = 0; i < NW; i++) read_word(i, "R1");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule